// File: doc/BRIEF.md
# Multi-Mode Page Table Walker

This block turns a linear address into a physical address by reading a chain of translation tables from memory, one entry per level. A caller hands it a linear address, a mode and the base pointer of the top table. The walker then issues one memory read at a time. Each returned entry either points to the next table, maps a page, or ends the walk with a fault. The walker finishes with a single response that carries the physical address, the page size as a log2 value, a fault flag and the level at which the walk stopped.

Three modes are supported. The first has two levels of 32-bit entries and 10-bit indices. The second has three levels of 64-bit entries and a 4-entry top table. The third has four levels of 64-bit entries over a 48-bit linear address. When an upper-level entry has its size flag set, the walk ends early with a large page. Its size is set by the linear-address bits that have not yet been used as an index. Entries that are not present, or that break the reserved-bit rules, end the walk with a fault.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle, a request is taken when `req_valid` and `req_ready` are both high at a clock edge, and `mem_req_valid` is never high while the walker is idle.
- R2: While `mem_req_valid` is high and `mem_req_ready` is low, the read stays requested on the next cycle with the same `mem_req_addr`.
- R3: Mode encoding on `req_mode` is 0 = two-level, 1 = three-level, and 2 or 3 = four-level. Each fetch address is the current table base with its low 12 bits cleared, plus the index times the entry size. The entry size is 4 bytes in the two-level mode and 8 bytes in the others. In the two-level mode, linear bits 31:22 then 21:12 are the indices.
- R4: In the three-level mode the indices are linear bits 31:30, then 29:21, then 20:12. In the four-level mode they are 47:39, 38:30, 29:21 and 20:12.
- R5: The first table base is `req_root`, and its bits 11:0 are ignored. Each later base is the entry's frame field: bits PA_W-1:12 of a 64-bit entry, or bits 31:12 of a 32-bit entry.
- R6: An entry whose bit 0 is clear ends the walk with `rsp_fault`=1, `rsp_fault_level` set to the level of that entry (top = 0), and `rsp_paddr` and `rsp_page_shift` both 0.
- R7: In the 64-bit-entry modes, a present entry with any bit at or above PA_W set ends the walk with a fault at that level.
- R8: At a level that is not the last, a present entry with bit 7 set maps a large page. `rsp_page_shift` equals the count of unconsumed linear bits (22 for two-level level 0, 30 and 21 for three-level levels 0 and 1). `rsp_paddr` combines the frame's upper bits with the linear address's low `rsp_page_shift` bits, and `rsp_fault_level` gives the mapping level.
- R9: An entry at the last level always maps a 4 KB page (`rsp_page_shift`=12), whatever the value of its bit 7.
- R10: A large-page entry whose frame has any bit set below the page alignment ends the walk with a fault at that level.
- R11: Each accepted request produces exactly one `rsp_valid` pulse, one cycle long. A walk reads at most as many entries as its mode has levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | VA_W | Linear address to translate |
| req_mode | input | 2 | Walk mode (see R3) |
| req_root | input | PA_W | Base address of the top table |
| mem_req_valid | output | 1 | Entry read requested |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry data (low 32 bits used in two-level mode) |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_page_shift | output | 6 | log2 of mapped page size |
| rsp_fault | output | 1 | Walk ended without translation |
| rsp_fault_level | output | 2 | Level where the walk ended |

## Verification
On every cycle, the assertions check the memory read hold rule and that no read is requested while idle. They also check that the response is a one-cycle pulse, that fetch addresses are aligned to the entry size, that the level counter stays within the mode's depth, and that success and fault results have the right shape. Only the bench scenarios can show that the index slices, base chaining, large-page sizes, last-level handling and reserved-bit faults give the right address and level for each mode. In those scenarios, every untabled address reads back as not present, so any wrong fetch address shows up as a mismatch.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

  typedef enum logic [1:0] {
    PTW_TWO   = 2'd0,
    PTW_THREE = 2'd1,
    PTW_FOUR  = 2'd2
  } ptw_mode_e;

  function automatic ptw_mode_e norm_mode(input logic [1:0] raw);
    case (raw)
      2'd0:    return PTW_TWO;
      2'd1:    return PTW_THREE;
      default: return PTW_FOUR;
    endcase
  endfunction

  // Number of linear bits still unconsumed after indexing at level lv.
  function automatic logic [5:0] lvl_shift(input ptw_mode_e m, input logic [1:0] lv);
    case (m)
      PTW_TWO:   return (lv == 2'd0) ? 6'd22 : 6'd12;
      PTW_THREE: case (lv)
                   2'd0:    return 6'd30;
                   2'd1:    return 6'd21;
                   default: return 6'd12;
                 endcase
      default:   case (lv)
                   2'd0:    return 6'd39;
                   2'd1:    return 6'd30;
                   2'd2:    return 6'd21;
                   default: return 6'd12;
                 endcase
    endcase
  endfunction

  function automatic logic [3:0] idx_bits(input ptw_mode_e m, input logic [1:0] lv);
    if (m == PTW_TWO) return 4'd10;
    if (m == PTW_THREE && lv == 2'd0) return 4'd2;
    return 4'd9;
  endfunction

  function automatic logic [1:0] last_lvl(input ptw_mode_e m);
    case (m)
      PTW_TWO:   return 2'd1;
      PTW_THREE: return 2'd2;
      default:   return 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] ent_log2(input ptw_mode_e m);
    return (m == PTW_TWO) ? 2'd2 : 2'd3;
  endfunction

endpackage

// File: rtl/ptw_index.sv
`timescale 1ns/1ps
module ptw_index
  import ptw_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 40
) (
  input  ptw_mode_e         mode,
  input  logic [1:0]        lvl,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [PA_W-1:0]   base,
  output logic [PA_W-1:0]   fetch_addr,
  output logic [5:0]        shift
);
  localparam logic [PA_W-1:0] PAGE_MASK = PA_W'(12'hfff);

  logic [9:0] idx_mask;
  logic [9:0] idx;
  logic [1:0] esz;

  assign shift    = lvl_shift(mode, lvl);
  assign esz      = ent_log2(mode);
  assign idx_mask = (10'd1 << idx_bits(mode, lvl)) - 10'd1;
  assign idx      = 10'(vaddr >> shift) & idx_mask;

  assign fetch_addr = (base & ~PAGE_MASK) + (PA_W'(idx) << esz);
endmodule

// File: rtl/ptw_entry_dec.sv
`timescale 1ns/1ps
module ptw_entry_dec
  import ptw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic [63:0]       data,
  input  ptw_mode_e         mode,
  input  logic              is_last,
  input  logic [5:0]        shift,
  output logic              present,
  output logic              leaf,
  output logic              rsvd_err,
  output logic [PA_W-1:0]   frame
);
  localparam logic [63:0] HI_MASK = ~((64'd1 << PA_W) - 64'd1);

  logic            wide;
  logic            upper_bad;
  logic            align_bad;
  logic [PA_W-1:0] low_mask;

  assign wide      = (mode != PTW_TWO);
  assign present   = data[0];
  assign leaf      = is_last | data[7];
  assign frame     = wide ? {data[PA_W-1:12], 12'h000}
                          : PA_W'({data[31:12], 12'h000});
  assign upper_bad = wide && (|(data & HI_MASK));
  assign low_mask  = (PA_W'(1) << shift) - PA_W'(1);
  assign align_bad = data[7] && !is_last && (|(frame & low_mask));
  assign rsvd_err  = present && (upper_bad || align_bad);
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_mode,
  input  logic [PA_W-1:0]   req_root,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [5:0]        rsp_page_shift,
  output logic              rsp_fault,
  output logic [1:0]        rsp_fault_level
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_e;

  st_e             st;
  ptw_mode_e       mode_q;
  logic [VA_W-1:0] vaddr_q;
  logic [PA_W-1:0] base_q;
  logic [1:0]      lvl_q;
  logic [PA_W-1:0] paddr_q;
  logic [5:0]      pshift_q;
  logic            fault_q;
  logic [1:0]      flvl_q;

  logic [PA_W-1:0] fetch_addr;
  logic [5:0]      cur_shift;
  logic            is_last;
  logic            ent_present, ent_leaf, ent_rsvd;
  logic [PA_W-1:0] ent_frame;

  // Named internal events
  logic ev_accept, ev_return, ev_fault, ev_map, ev_descend;

  function automatic logic [PA_W-1:0] merge_pa(input logic [PA_W-1:0] fr,
                                               input logic [VA_W-1:0] va,
                                               input logic [5:0]      sh);
    logic [PA_W-1:0] m;
    m = (PA_W'(1) << sh) - PA_W'(1);
    return (fr & ~m) | (va[PA_W-1:0] & m);
  endfunction

  ptw_index #(.VA_W(VA_W), .PA_W(PA_W)) u_index (
    .mode       (mode_q),
    .lvl        (lvl_q),
    .vaddr      (vaddr_q),
    .base       (base_q),
    .fetch_addr (fetch_addr),
    .shift      (cur_shift)
  );

  assign is_last = (lvl_q == last_lvl(mode_q));

  ptw_entry_dec #(.PA_W(PA_W)) u_dec (
    .data     (mem_rsp_data),
    .mode     (mode_q),
    .is_last  (is_last),
    .shift    (cur_shift),
    .present  (ent_present),
    .leaf     (ent_leaf),
    .rsvd_err (ent_rsvd),
    .frame    (ent_frame)
  );

  assign ev_accept  = req_valid && req_ready;
  assign ev_return  = (st == S_WAIT) && mem_rsp_valid;
  assign ev_fault   = ev_return && (!ent_present || ent_rsvd);
  assign ev_map     = ev_return && ent_present && !ent_rsvd && ent_leaf;
  assign ev_descend = ev_return && ent_present && !ent_rsvd && !ent_leaf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= PTW_TWO;
      vaddr_q  <= '0;
      base_q   <= '0;
      lvl_q    <= '0;
      paddr_q  <= '0;
      pshift_q <= '0;
      fault_q  <= 1'b0;
      flvl_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (ev_accept) begin
          mode_q  <= norm_mode(req_mode);
          vaddr_q <= req_vaddr;
          base_q  <= req_root;
          lvl_q   <= '0;
          st      <= S_ISSUE;
        end
        S_ISSUE: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: begin
          if (ev_fault) begin
            fault_q  <= 1'b1;
            flvl_q   <= lvl_q;
            paddr_q  <= '0;
            pshift_q <= '0;
            st       <= S_DONE;
          end else if (ev_map) begin
            fault_q  <= 1'b0;
            flvl_q   <= lvl_q;
            paddr_q  <= merge_pa(ent_frame, vaddr_q, cur_shift);
            pshift_q <= cur_shift;
            st       <= S_DONE;
          end else if (ev_descend) begin
            base_q <= ent_frame;
            lvl_q  <= lvl_q + 2'd1;
            st     <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready       = (st == S_IDLE);
  assign mem_req_valid   = (st == S_ISSUE);
  assign mem_req_addr    = fetch_addr;
  assign rsp_valid       = (st == S_DONE);
  assign rsp_paddr       = paddr_q;
  assign rsp_page_shift  = pshift_q;
  assign rsp_fault       = fault_q;
  assign rsp_fault_level = flvl_q;

  // Assertions
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid); // R1
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R2
  AST_FETCH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mode_q == PTW_TWO ? mem_req_addr[1:0] == 2'b00
                                         : mem_req_addr[2:0] == 3'b000)); // R3
  AST_FAULT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0 && rsp_page_shift == 6'd0); // R6
  AST_MAP_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_page_shift >= 6'd12
                                && rsp_paddr[11:0] == vaddr_q[11:0]); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready); // R11
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    st != S_IDLE |-> lvl_q <= last_lvl(mode_q)); // R11
endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  localparam int VA_W = 48;
  localparam int PA_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0]      req_mode = '0;
  logic [PA_W-1:0] req_root = '0;
  logic            mem_req_valid;
  logic            mem_req_ready;
  logic [PA_W-1:0] mem_req_addr;
  logic            mem_rsp_valid;
  logic [63:0]     mem_rsp_data;
  logic            rsp_valid;
  logic [PA_W-1:0] rsp_paddr;
  logic [5:0]      rsp_page_shift;
  logic            rsp_fault;
  logic [1:0]      rsp_fault_level;

  ptw_walker #(.VA_W(VA_W), .PA_W(PA_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_mode(req_mode), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_page_shift(rsp_page_shift),
    .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level)
  );

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [PA_W-1:0] pa;
    logic [5:0]      sh;
    logic            f;
    logic [1:0]      lv;
    string           tag;
  } exp_t;
  exp_t sb[$];

  logic [63:0] mem [logic [PA_W-1:0]];

  function automatic logic [63:0] rd(input logic [PA_W-1:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0; // untabled: not present
  endfunction

  task automatic chk(input bit ok, input string tag, input string act, input string expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %s expected %s", tag, act, expv);
    end
  endtask

  // Memory responder: stalls on some cycles, answers one cycle after the handshake
  bit              pend = 1'b0;
  logic [PA_W-1:0] pend_addr = '0;
  int              cyc = 0;
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = pend;
      mem_rsp_data  = pend ? rd(pend_addr) : 64'd0;
      pend = 1'b0;
      cyc++;
      mem_req_ready = (cyc % 3) != 1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        pend      = 1'b1;
        pend_addr = mem_req_addr;
      end
    end
  end

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R11 unexpected response", "rsp_valid=1", "none");
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rsp_paddr == e.pa && rsp_page_shift == e.sh &&
              rsp_fault == e.f && rsp_fault_level == e.lv, e.tag,
              $sformatf("pa=%0h sh=%0d f=%0b lv=%0d", rsp_paddr, rsp_page_shift, rsp_fault, rsp_fault_level),
              $sformatf("pa=%0h sh=%0d f=%0b lv=%0d", e.pa, e.sh, e.f, e.lv));
        end
      end
    end
  end

  task automatic walk(input logic [1:0] m, input logic [VA_W-1:0] va,
                      input logic [PA_W-1:0] root, input logic [PA_W-1:0] pa,
                      input int sh, input bit f, input int lv, input string tag);
    exp_t e;
    e.pa = pa; e.sh = 6'(sh); e.f = f; e.lv = 2'(lv); e.tag = tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    sb.push_back(e);
    req_valid = 1'b1; req_vaddr = va; req_mode = m; req_root = root;
    @(negedge clk);
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  bit wdog = 1'b0;

  initial begin
    // two-level tables, root at 0x1000 (given with junk low bits)
    mem[40'h1004]  = 64'h0000_2003;        // L0 idx1 -> table 0x2000
    mem[40'h200C]  = 64'h0055_5001;        // L1 idx3 -> 4K frame
    mem[40'h2010]  = 64'h0077_7081;        // L1 idx4, bit7 set at last level
    mem[40'h1008]  = 64'h0C00_0081;        // L0 idx2, 4MB page
    mem[40'h100C]  = 64'h0C00_1081;        // L0 idx3, misaligned 4MB
    // three-level tables, root 0x10000
    mem[40'h10008] = 64'h0002_0063;
    mem[40'h20018] = 64'h0003_0001;
    mem[40'h30018] = 64'hAB_CDE0_0001;
    mem[40'h20020] = 64'h1240_0081;        // 2MB
    mem[40'h10010] = 64'h40_0000_0081;     // 1GB at top
    mem[40'h10018] = 64'h0001_0000_0002_0001; // bit 48 set
    // four-level tables, root 0x40000
    mem[40'h40008] = 64'h0005_0001;
    mem[40'h50010] = 64'h0006_0001;
    mem[40'h60018] = 64'h0007_0001;
    mem[40'h70020] = 64'h99_9000_0081;     // bit7 at last level
    mem[40'h60020] = 64'h8000_0000_0007_0001; // bit 63 set

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", $sformatf("%0b", req_ready), "1");
    chk(rsp_valid == 1'b0, "R11 reset rsp_valid", $sformatf("%0b", rsp_valid), "0");
    chk(mem_req_valid == 1'b0, "R1 reset mem_req_valid", $sformatf("%0b", mem_req_valid), "0");

    fork
      begin
        walk(2'd0, 48'hFFFF_0040_3123, 40'h1ABC, 40'h555123, 12, 0, 1, "R3 R5 two-level 4K");
        walk(2'd0, 48'h0000_0040_4456, 40'h1ABC, 40'h777456, 12, 0, 1, "R9 two-level last-level bit7");
        walk(2'd0, 48'h0000_0080_1234, 40'h1ABC, 40'h0C001234, 22, 0, 0, "R8 two-level 4MB");
        walk(2'd0, 48'h0000_00C0_0000, 40'h1ABC, 40'h0, 0, 1, 0, "R10 two-level misaligned 4MB");
        walk(2'd0, 48'h0000_0100_0000, 40'h1ABC, 40'h0, 0, 1, 0, "R6 not present level0");
        walk(2'd0, 48'h0000_0040_5000, 40'h1ABC, 40'h0, 0, 1, 1, "R6 not present level1");
        walk(2'd1, 48'h0000_4060_3ABC, 40'h10000, 40'hAB_CDE0_0ABC, 12, 0, 2, "R4 three-level 4K");
        walk(2'd1, 48'h0000_4080_0123, 40'h10000, 40'h1240_0123, 21, 0, 1, "R8 three-level 2MB");
        walk(2'd1, 48'h0000_8123_4567, 40'h10000, 40'h40_0123_4567, 30, 0, 0, "R8 three-level 1GB");
        walk(2'd1, 48'h0000_C000_0000, 40'h10000, 40'h0, 0, 1, 0, "R7 three-level high bit");
        walk(2'd2, 48'h0080_8060_4567, 40'h40000, 40'h99_9000_0567, 12, 0, 3, "R4 R9 four-level 4K");
        walk(2'd3, 48'h0080_8060_4567, 40'h40000, 40'h99_9000_0567, 12, 0, 3, "R3 mode3 as four-level");
        walk(2'd2, 48'h0080_8060_5000, 40'h40000, 40'h0, 0, 1, 3, "R6 four-level level3");
        walk(2'd2, 48'h0080_8080_0000, 40'h40000, 40'h0, 0, 1, 2, "R7 four-level bit63");
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R11 idle after walks",
            $sformatf("%0b%0b", req_ready, rsp_valid), "10");
      end
      begin
        repeat (50000) @(posedge clk);
        wdog = 1'b1;
      end
    join_any
    disable fork;
    if (wdog) chk(1'b0, "R11 watchdog", "hung", "done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule